// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places incoming frames into a ring of receive descriptors kept in on-chip registers. Software prepares each descriptor by marking it empty. It sets a wrap flag on the descriptor that closes the ring. Frames arrive as a byte stream. Each beat carries a valid strobe, start and end markers, and an error marker.

On a frame start the engine looks at the descriptor at the ring index. If that descriptor is empty, the engine claims it and streams the frame bytes into a buffer write port, at an address formed from the ring index and the byte offset. At the end of the frame it writes the byte count and the error flags back into the descriptor and clears its empty flag. It then moves the ring index on.

If the descriptor is not empty, the engine drops the frame, raises a sticky busy event and halts. While halted it drops every frame until software clears the halt. A held stop request lets the frame in progress finish, raises a stop-complete event and refuses new frames for as long as the request stays high.

Top module: `rx_bd_ring`

## Requirements
- R1: After a synchronous reset: busy_evt, halted, stop_done_evt and buf_we are 0 and cur_idx is 0. Every descriptor reads back with empty=0, wrap=0, err=0 and len=0.
- R2: A software write (sw_we) sets empty and wrap from sw_empty and sw_wrap, and clears len and err to zero. A frame fills only the descriptor at cur_idx, and only when its empty flag is 1. Write-back clears empty and leaves wrap unchanged.
- R3: The written-back len is the number of accepted bytes in the frame, counting the 4 trailing check bytes. It saturates at the all-ones value.
- R4: Byte k of a frame goes out on the buffer port one cycle after its beat, at buf_addr = {ring index, k}. Bytes are written only when k < max_len and k < BUF_BYTES.
- R5: The err field is 3 bits. Bit 0 is set when len < min_len. Bit 1 is set when len > max_len. Bit 2 is set when in_err was high on any beat of the frame.
- R6: After a write-back, cur_idx becomes 0 if the filled descriptor had wrap=1 or was the last entry. Otherwise it becomes cur_idx+1.
- R7: A frame start that finds the current descriptor not empty sets busy_evt and halted. The frame is dropped, with no buffer write, no descriptor change and no index change.
- R8: busy_evt holds until a cycle with evt_clr[0]=1. halted holds until a cycle with clr_halt=1. A new set in the same cycle wins over the clear.
- R9: A frame that starts while halted is dropped entirely. It does not set busy_evt and writes neither buffer nor descriptor.
- R10: While stop_req is high, a frame already in progress completes. stop_done_evt sets in the cycle after no frame is in progress. Frames that start while stop_req is high are dropped. evt_clr[1]=1 clears stop_done_evt once stop_req is low.
- R11: Beats with in_valid=1 but no in_sof, arriving outside a frame, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Error marker on this beat |
| in_data | input | 8 | Frame byte |
| max_len | input | LEN_W | Largest allowed frame length |
| min_len | input | LEN_W | Smallest allowed frame length |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_addr | input | IDX_W | Descriptor written by software |
| sw_empty | input | 1 | Empty flag to write |
| sw_wrap | input | 1 | Wrap flag to write |
| sw_rd_addr | input | IDX_W | Descriptor to read back |
| rd_empty | output | 1 | Registered empty flag of the read descriptor |
| rd_wrap | output | 1 | Registered wrap flag of the read descriptor |
| rd_err | output | 3 | Registered error field of the read descriptor |
| rd_len | output | LEN_W | Registered length of the read descriptor |
| stop_req | input | 1 | Graceful stop request, level |
| evt_clr | input | 2 | Event clear: bit 0 busy, bit 1 stop-complete |
| clr_halt | input | 1 | Resume reception after a halt |
| busy_evt | output | 1 | Sticky busy event |
| halted | output | 1 | Reception halted |
| stop_done_evt | output | 1 | Sticky stop-complete event |
| cur_idx | output | IDX_W | Current ring index |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | IDX_W+log2(BUF_BYTES) | Buffer byte address |
| buf_data | output | 8 | Buffer byte |

## Verification
On every cycle the assertions check the rules that hold at all times. Write-back lands only on a descriptor that was empty, and a written length is never zero. halted is never set while a frame is being received, and busy_evt stays set until it is cleared. A held stop request never lets a new frame be claimed. The bench scenarios are needed for the value-level behaviour. That covers lengths at the limits, the error-flag encoding, buffer contents and addresses, ring wrap on the flag versus on the last entry, the recovery sequence after a halt, and the timing of the stop-complete event.

// File: rtl/rx_bd_pkg.sv
package rx_bd_pkg;
  localparam int ERR_W     = 3;
  localparam int ERR_SHORT = 0;
  localparam int ERR_LONG  = 1;
  localparam int ERR_MARK  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_bd_slot.sv
module rx_bd_slot
  import rx_bd_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_hit,
  input  logic [LEN_W-1:0] wb_len,
  input  logic [ERR_W-1:0] wb_err,
  input  logic             sw_hit,
  input  logic             sw_empty,
  input  logic             sw_wrap,
  output logic             empty,
  output logic             wrap,
  output logic [ERR_W-1:0] err,
  output logic [LEN_W-1:0] len
);
  // Engine write-back has priority over a software write to the same entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b0;
      wrap  <= 1'b0;
      err   <= '0;
      len   <= '0;
    end else if (wb_hit) begin
      empty <= 1'b0;
      err   <= wb_err;
      len   <= wb_len;
    end else if (sw_hit) begin
      empty <= sw_empty;
      wrap  <= sw_wrap;
      err   <= '0;
      len   <= '0;
    end
  end

  // R2: after a software-only write the length reads zero
  a_r2_sw_clears_len: assert property (@(posedge clk) disable iff (rst)
    (sw_hit && !wb_hit) |=> (len == '0));
endmodule

// File: rtl/rx_bd_meter.sv
module rx_bd_meter
  import rx_bd_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int BUF_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adv,
  input  logic             mark,
  input  logic [LEN_W-1:0] max_len,
  input  logic [LEN_W-1:0] min_len,
  output logic [LEN_W-1:0] offs,
  output logic [LEN_W-1:0] total,
  output logic             store,
  output logic [ERR_W-1:0] err_final
);
  localparam logic [LEN_W-1:0] BUF_LIM = LEN_W'(BUF_BYTES);

  logic [LEN_W-1:0] cnt_q;
  logic             err_q;
  logic             mark_all;

  assign offs     = start ? '0 : cnt_q;
  assign total    = (&offs) ? offs : offs + 1'b1;
  assign store    = (offs < max_len) && (offs < BUF_LIM);
  assign mark_all = (start ? 1'b0 : err_q) | mark;

  always_comb begin
    err_final            = '0;
    err_final[ERR_SHORT] = (total < min_len);
    err_final[ERR_LONG]  = (total > max_len);
    err_final[ERR_MARK]  = mark_all;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (adv) begin
      cnt_q <= total;
      err_q <= mark_all;
    end
  end
endmodule

// File: rtl/rx_bd_ctrl.sv
module rx_bd_ctrl
  import rx_bd_pkg::*;
#(
  parameter int NUM_DESC  = 8,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int BOFF_W   = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              cur_empty,
  input  logic              cur_wrap,
  input  logic              stop_req,
  input  logic [1:0]        evt_clr,
  input  logic              clr_halt,
  input  logic [BOFF_W-1:0] offs_lo,
  input  logic              store,
  output logic              start,
  output logic              adv,
  output logic              wb_en,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              halted,
  output logic              busy_evt,
  output logic              stop_done_evt,
  output logic              buf_we,
  output logic [IDX_W+BOFF_W-1:0] buf_addr,
  output logic [7:0]        buf_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  rx_state_e st, st_nx;
  logic      sof_go, blocked, claim, refuse;
  logic [IDX_W-1:0] idx_nx;

  assign sof_go  = in_valid && in_sof && (st == ST_IDLE);
  assign blocked = halted || stop_req;
  assign claim   = sof_go && !blocked && cur_empty;
  assign refuse  = sof_go && !blocked && !cur_empty;
  assign start   = claim;
  assign adv     = claim || ((st == ST_RECV) && in_valid);
  assign wb_en   = adv && in_eof;
  assign idx_nx  = (cur_wrap || (cur_idx == LAST_IDX)) ? '0 : cur_idx + 1'b1;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (sof_go && !in_eof) st_nx = claim ? ST_RECV : ST_DROP;
      ST_RECV: if (in_valid && in_eof) st_nx = ST_IDLE;
      ST_DROP: if (in_valid && in_eof) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      cur_idx       <= '0;
      halted        <= 1'b0;
      busy_evt      <= 1'b0;
      stop_done_evt <= 1'b0;
      buf_we        <= 1'b0;
      buf_addr      <= '0;
      buf_data      <= '0;
    end else begin
      st <= st_nx;
      if (wb_en) cur_idx <= idx_nx;
      if (refuse)        halted <= 1'b1;
      else if (clr_halt) halted <= 1'b0;
      if (refuse)          busy_evt <= 1'b1;
      else if (evt_clr[0]) busy_evt <= 1'b0;
      if (stop_req && (st != ST_RECV)) stop_done_evt <= 1'b1;
      else if (evt_clr[1])             stop_done_evt <= 1'b0;
      buf_we   <= adv && store;
      buf_addr <= {cur_idx, offs_lo};
      buf_data <= in_data;
    end
  end

  // R7: never halted while a frame is being received
  a_r7_no_halt_in_frame: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECV) |-> !halted);
  // R8: busy stays set until its clear bit is seen
  a_r8_busy_sticky: assert property (@(posedge clk) disable iff (rst)
    (busy_evt && !evt_clr[0]) |=> busy_evt);
  // R10: a held stop request never lets a new frame be claimed
  a_r10_stop_blocks: assert property (@(posedge clk) disable iff (rst)
    (stop_req && (st != ST_RECV)) |=> (st != ST_RECV));
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
  import rx_bd_pkg::*;
#(
  parameter int NUM_DESC  = 8,
  parameter int LEN_W     = 12,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int BOFF_W   = $clog2(BUF_BYTES),
  localparam int BUF_AW   = IDX_W + BOFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic [7:0]        in_data,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [LEN_W-1:0]  min_len,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_addr,
  input  logic              sw_empty,
  input  logic              sw_wrap,
  input  logic [IDX_W-1:0]  sw_rd_addr,
  output logic              rd_empty,
  output logic              rd_wrap,
  output logic [2:0]        rd_err,
  output logic [LEN_W-1:0]  rd_len,
  input  logic              stop_req,
  input  logic [1:0]        evt_clr,
  input  logic              clr_halt,
  output logic              busy_evt,
  output logic              halted,
  output logic              stop_done_evt,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [7:0]        buf_data
);
  logic [NUM_DESC-1:0] s_empty, s_wrap;
  logic [ERR_W-1:0]    s_err [NUM_DESC];
  logic [LEN_W-1:0]    s_len [NUM_DESC];

  logic             start, adv, wb_en, store;
  logic [LEN_W-1:0] offs, total;
  logic [ERR_W-1:0] err_final;
  logic             cur_empty, cur_wrap;

  assign cur_empty = s_empty[cur_idx];
  assign cur_wrap  = s_wrap[cur_idx];

  rx_bd_meter #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_meter (
    .clk(clk), .rst(rst), .start(start), .adv(adv), .mark(in_err),
    .max_len(max_len), .min_len(min_len), .offs(offs), .total(total),
    .store(store), .err_final(err_final)
  );

  rx_bd_ctrl #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .cur_empty(cur_empty),
    .cur_wrap(cur_wrap), .stop_req(stop_req), .evt_clr(evt_clr),
    .clr_halt(clr_halt), .offs_lo(offs[BOFF_W-1:0]), .store(store),
    .start(start), .adv(adv), .wb_en(wb_en), .cur_idx(cur_idx),
    .halted(halted), .busy_evt(busy_evt), .stop_done_evt(stop_done_evt),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data)
  );

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_slot
    logic wb_hit, sw_hit;
    assign wb_hit = wb_en && (cur_idx == IDX_W'(i));
    assign sw_hit = sw_we && (sw_addr == IDX_W'(i));
    rx_bd_slot #(.LEN_W(LEN_W)) u_slot (
      .clk(clk), .rst(rst), .wb_hit(wb_hit), .wb_len(total),
      .wb_err(err_final), .sw_hit(sw_hit), .sw_empty(sw_empty),
      .sw_wrap(sw_wrap), .empty(s_empty[i]), .wrap(s_wrap[i]),
      .err(s_err[i]), .len(s_len[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_empty <= 1'b0;
      rd_wrap  <= 1'b0;
      rd_err   <= '0;
      rd_len   <= '0;
    end else begin
      rd_empty <= s_empty[sw_rd_addr];
      rd_wrap  <= s_wrap[sw_rd_addr];
      rd_err   <= s_err[sw_rd_addr];
      rd_len   <= s_len[sw_rd_addr];
    end
  end

  // R2: write-back only lands on a descriptor that was empty
  a_r2_fill_empty_only: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> cur_empty);
  // R3: a completed frame never reports zero length
  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (total != '0));
endmodule

// File: tb/rx_bd_ring_bench.sv
module rx_bd_ring_bench;
  localparam int ND = 8;
  localparam int LW = 12;
  localparam int BB = 64;
  localparam int MAXL = 40;
  localparam int MINL = 8;

  // {length, error-marker}
  localparam logic [12:0] VEC [6] = '{
    {12'd20, 1'b0}, {12'd8, 1'b0}, {12'd7, 1'b0},
    {12'd41, 1'b0}, {12'd40, 1'b0}, {12'd12, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
  logic [7:0] in_data = '0;
  logic [LW-1:0] max_len = LW'(MAXL), min_len = LW'(MINL);
  logic sw_we = 0, sw_empty = 0, sw_wrap = 0;
  logic [2:0] sw_addr = '0, sw_rd_addr = '0;
  logic rd_empty, rd_wrap;
  logic [2:0] rd_err;
  logic [LW-1:0] rd_len;
  logic stop_req = 0, clr_halt = 0;
  logic [1:0] evt_clr = '0;
  logic busy_evt, halted, stop_done_evt, buf_we;
  logic [2:0] cur_idx;
  logic [8:0] buf_addr;
  logic [7:0] buf_data;

  int checks = 0, errors = 0, wr_cnt = 0;
  logic [7:0] cap [ND*BB];
  logic sd_during;

  always #4 clk = ~clk;

  rx_bd_ring #(.NUM_DESC(ND), .LEN_W(LW), .BUF_BYTES(BB)) u_rx_bd_ring (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err), .in_data(in_data),
    .max_len(max_len), .min_len(min_len), .sw_we(sw_we),
    .sw_addr(sw_addr), .sw_empty(sw_empty), .sw_wrap(sw_wrap),
    .sw_rd_addr(sw_rd_addr), .rd_empty(rd_empty), .rd_wrap(rd_wrap),
    .rd_err(rd_err), .rd_len(rd_len), .stop_req(stop_req),
    .evt_clr(evt_clr), .clr_halt(clr_halt), .busy_evt(busy_evt),
    .halted(halted), .stop_done_evt(stop_done_evt), .cur_idx(cur_idx),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data)
  );

  always @(negedge clk) if (buf_we) begin
    cap[buf_addr] = buf_data;
    wr_cnt = wr_cnt + 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_err(int n, bit m);
    return ((n < MINL) ? 1 : 0) | ((n > MAXL) ? 2 : 0) | (m ? 4 : 0);
  endfunction

  function automatic int nstore(int n);
    int r = n;
    if (r > MAXL) r = MAXL;
    if (r > BB) r = BB;
    return r;
  endfunction

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed + k * 7) & 255);
  endfunction

  task automatic send_frame(int n, bit m, int seed, int stop_at);
    sd_during = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sd_during = sd_during | stop_done_evt;
      in_valid = 1'b1;
      in_sof   = (k == 0);
      in_eof   = (k == n - 1);
      in_err   = m && (k == n / 2);
      in_data  = pat(seed, k);
      if (k == stop_at) stop_req = 1'b1;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
    @(negedge clk);
  endtask

  task automatic read_desc(int i);
    @(negedge clk);
    sw_rd_addr = 3'(i);
    @(negedge clk);
  endtask

  task automatic sw_write(int i, bit e, bit w);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = 3'(i); sw_empty = e; sw_wrap = w;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  initial begin
    int w0;
    int n;
    int nw;
    bit m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy_evt, 0);
    chk("R1 halted after reset", halted, 0);
    chk("R1 stop_done after reset", stop_done_evt, 0);
    chk("R1 cur_idx after reset", cur_idx, 0);
    chk("R1 buf_we after reset", buf_we, 0);
    read_desc(0);
    chk("R1 desc empty after reset", rd_empty, 0);
    chk("R1 desc len after reset", rd_len, 0);

    for (int i = 0; i < ND; i++) sw_write(i, 1'b1, i == ND - 1);
    read_desc(3);
    chk("R2 sw write empty", rd_empty, 1);
    chk("R2 sw write len", rd_len, 0);

    // table of frames into descriptors 0..5
    for (int i = 0; i < 6; i++) begin
      n = int'(VEC[i][12:1]);
      m = VEC[i][0];
      nw = nstore(n);
      w0 = wr_cnt;
      send_frame(n, m, i * 11 + 3, -1);
      chk("R4 stored byte count", wr_cnt - w0, nw);
      chk("R4 first byte", cap[i*BB], pat(i * 11 + 3, 0));
      chk("R4 last stored byte", cap[i*BB + nw - 1], pat(i * 11 + 3, nw - 1));
      read_desc(i);
      chk("R2 empty cleared", rd_empty, 0);
      chk("R3 length with check bytes", rd_len, n);
      chk("R5 error field", rd_err, exp_err(n, m));
      chk("R6 index advance", cur_idx, i + 1);
    end

    send_frame(16, 0, 5, -1);
    send_frame(9, 0, 6, -1);
    chk("R6 wrap after flagged last entry", cur_idx, 0);
    read_desc(7);
    chk("R2 wrap kept after write-back", rd_wrap, 1);

    // ring full: descriptor 0 is not empty
    w0 = wr_cnt;
    send_frame(10, 0, 9, -1);
    chk("R7 busy set", busy_evt, 1);
    chk("R7 halted set", halted, 1);
    chk("R7 no buffer write", wr_cnt - w0, 0);
    chk("R7 index held", cur_idx, 0);
    read_desc(0);
    chk("R7 descriptor untouched", rd_len, 20);

    @(negedge clk); evt_clr = 2'b01;
    @(negedge clk); evt_clr = 2'b00;
    chk("R8 busy cleared", busy_evt, 0);
    chk("R8 halted held", halted, 1);

    sw_write(0, 1'b1, 1'b1);
    w0 = wr_cnt;
    send_frame(10, 0, 9, -1);
    chk("R9 busy not set while halted", busy_evt, 0);
    chk("R9 no buffer write while halted", wr_cnt - w0, 0);
    read_desc(0);
    chk("R9 descriptor untouched while halted", rd_empty, 1);

    @(negedge clk); clr_halt = 1'b1;
    @(negedge clk); clr_halt = 1'b0;
    chk("R8 halt cleared", halted, 0);

    // stray beat outside a frame
    w0 = wr_cnt;
    @(negedge clk); in_valid = 1'b1; in_data = 8'hA5;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk("R11 stray beat ignored", wr_cnt - w0, 0);
    chk("R11 index unchanged", cur_idx, 0);

    send_frame(12, 0, 21, -1);
    read_desc(0);
    chk("R2 filled after recovery", rd_len, 12);
    chk("R6 wrap on flag at non-last", cur_idx, 0);

    // graceful stop
    sw_write(0, 1'b1, 1'b0);
    sw_write(1, 1'b1, 1'b0);
    send_frame(10, 0, 33, 3);
    chk("R10 no stop event mid-frame", sd_during, 0);
    chk("R10 stop event after frame", stop_done_evt, 1);
    read_desc(0);
    chk("R10 frame in progress completed", rd_len, 10);
    chk("R10 index after completed frame", cur_idx, 1);
    w0 = wr_cnt;
    send_frame(6, 0, 44, -1);
    chk("R10 frame dropped while stopping", wr_cnt - w0, 0);
    chk("R10 index held while stopping", cur_idx, 1);
    read_desc(1);
    chk("R10 descriptor untouched while stopping", rd_empty, 1);
    @(negedge clk); stop_req = 1'b0; evt_clr = 2'b10;
    @(negedge clk); evt_clr = 2'b00;
    chk("R10 stop event cleared", stop_done_evt, 0);
    send_frame(9, 0, 50, -1);
    chk("R10 reception resumes", cur_idx, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule